// File: doc/BRIEF.md
# Two-Deep Latched Interrupt Aggregator

The aggregator gathers up to 32 event inputs into an identity register and drives one interrupt line toward a processor. Each event input is a level. An event is the cycle in which that level goes from low to high. An event is recorded only for a source whose enable bit is set. A mask register then decides which recorded events may take part in raising the interrupt. Every identity bit has room for one further event queued behind the visible one. When software clears a bit that has an event queued, the queued event moves up, so the bit is at once set again.

The aggregator's own unmasked pending bits are ORed with summary levels from subordinate units. The master enable bit gates that combined condition. The interrupt line is a registered level. It is set only when the gated condition rises from 0 to 1. It is cleared only when software turns off the master enable. A handler therefore turns off the master enable, clears what it has serviced, and turns the master enable back on. If anything is still pending at that point, the line sees a fresh rising edge.

Registers are reached through a single-cycle port. A write takes effect at the clock edge on which the write strobe is sampled. A read is combinational on the address.

Top module: `irq_agg`

## Requirements
- R1: After reset the mask register reads all ones. The enable register, the identity register and the master-control register read zero, and `cpu_irq_o` is low.
- R2: An event is a low-to-high transition of an `evt_i` bit. It sets the matching identity bit (address 2) at the clock edge where the high level is first sampled, but only if the enable bit (address 1) is set. A level held high gives exactly one event, and an event on a disabled source leaves identity unchanged.
- R3: A recorded event whose mask bit (address 0, 1 = masked) is set shows in identity but cannot raise `cpu_irq_o`. Clearing its mask bit while the master enable is on raises the line one cycle later.
- R4: Writing ones to identity (address 2) clears those bits. When a bit holds two events, one clear leaves it set and a second clear empties it. A third event that arrives while both slots are full is dropped.
- R5: A clear and a new event on the same identity bit in the same cycle leave that bit holding exactly one event, whether it held zero or one event before.
- R6: `cpu_irq_o` goes high on the clock edge after the gated condition rises. It then stays high while the master enable stays on, even if the identity bits are cleared.
- R7: When the master enable is written to 0, `cpu_irq_o` goes low at the following clock edge. Events that arrive while the master enable is off stay pending and do not raise the line.
- R8: The master-control register (address 3) holds the master enable in bit 31. A read returns bit 31 = master enable, bit 30 = any unmasked identity bit pending, and bits [NUM_SUB-1:0] = the current subordinate summary levels; all other bits read 0. Subordinate levels raise the line only while the master enable is on.
- R9: Turning the master enable back on while a pending condition remains raises `cpu_irq_o` again one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_SRC | Event source levels |
| sub_pend_i | input | NUM_SUB | Subordinate unit summary levels |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 mask, 1 enable, 2 identity, 3 master control |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data for the addressed register |
| cpu_irq_o | output | 1 | Interrupt line to the processor |

## Verification
The bench exercises the queue depth. It puts three events on one bit and checks that exactly two clears empty it. A design with a single slot would empty after one clear, and one that does not drop the overflow would need a third. Same-cycle clear-and-event is driven into an empty bit and into a bit holding one event. A design that gave the clear priority would lose the new event. The edge rule is checked by clearing identity while the line is high, and by adding events while the master enable is off. A level-driven line would drop or rise at the wrong moment, and a design without the master-off re-edge would stay silent when the master enable is turned back on.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  typedef enum logic [1:0] {
    A_MASK  = 2'd0,
    A_EN    = 2'd1,
    A_IDENT = 2'd2,
    A_MCTL  = 2'd3
  } reg_addr_e;

  // Occupancy of one identity bit: 0 empty, 1 visible, 2 visible plus queued.
  // A clear removes one event only when one is visible; a new event adds one,
  // saturating at two.
  function automatic logic [1:0] slot_next(input logic [1:0] cnt,
                                           input logic clr,
                                           input logic ev);
    logic [2:0] t;
    t = {1'b0, cnt};
    if (clr && (cnt != 2'd0)) t = t - 3'd1;
    if (ev) t = t + 3'd1;
    if (t > 3'd2) t = 3'd2;
    return t[1:0];
  endfunction

endpackage

// File: rtl/irq_agg_edge_det.sv
module irq_agg_edge_det #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] lvl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_d <= '0;
    else        lvl_d <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_d;
endmodule

// File: rtl/irq_agg_slot.sv
module irq_agg_slot
  import irq_agg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ev_i,
  input  logic clr_i,
  output logic vis_o,
  output logic queued_o
);
  logic [1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= 2'd0;
    else        cnt_q <= slot_next(cnt_q, clr_i, ev_i);
  end

  assign vis_o    = (cnt_q != 2'd0);
  assign queued_o = (cnt_q == 2'd2);
endmodule

// File: rtl/irq_agg_regs.sv
module irq_agg_regs
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_SUB = 4,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_i,
  input  logic [1:0]         addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NUM_SRC-1:0] ident_i,
  input  logic [NUM_SUB-1:0] sub_i,
  input  logic               own_pend_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [NUM_SRC-1:0] mask_o,
  output logic [NUM_SRC-1:0] en_o,
  output logic               master_o,
  output logic [NUM_SRC-1:0] clr_o
);
  localparam int MBIT = DATA_W - 1;
  localparam int PBIT = DATA_W - 2;

  logic [NUM_SRC-1:0] mask_q, en_q;
  logic               master_q;
  reg_addr_e          a;

  assign a = reg_addr_e'(addr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '1;
      en_q     <= '0;
      master_q <= 1'b0;
    end else if (we_i) begin
      case (a)
        A_MASK:  mask_q   <= wdata_i[NUM_SRC-1:0];
        A_EN:    en_q     <= wdata_i[NUM_SRC-1:0];
        A_MCTL:  master_q <= wdata_i[MBIT];
        default: ;
      endcase
    end
  end

  assign clr_o = (we_i && a == A_IDENT) ? wdata_i[NUM_SRC-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    case (a)
      A_MASK:  rdata_o = DATA_W'(mask_q);
      A_EN:    rdata_o = DATA_W'(en_q);
      A_IDENT: rdata_o = DATA_W'(ident_i);
      default: begin
        rdata_o[NUM_SUB-1:0] = sub_i;
        rdata_o[PBIT]        = own_pend_i;
        rdata_o[MBIT]        = master_q;
      end
    endcase
  end

  assign mask_o   = mask_q;
  assign en_o     = en_q;
  assign master_o = master_q;
endmodule

// File: rtl/irq_agg_line.sv
module irq_agg_line (
  input  logic clk,
  input  logic rst_n,
  input  logic master_i,
  input  logic cond_i,
  output logic gated_o,
  output logic irq_o
);
  logic gated_d, irq_q;

  assign gated_o = master_i & cond_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gated_d <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      gated_d <= gated_o;
      if (gated_o && !gated_d) irq_q <= 1'b1;
      else if (!master_i)      irq_q <= 1'b0;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_agg.sv
module irq_agg #(
  parameter int NUM_SRC = 32,
  parameter int NUM_SUB = 4,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [NUM_SUB-1:0] sub_pend_i,
  input  logic               reg_we_i,
  input  logic [1:0]         reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               cpu_irq_o
);
  logic [NUM_SRC-1:0] ev_pulse, latch_ev, clr_vec;
  logic [NUM_SRC-1:0] ident_vis, ident_q, mask_q, en_q;
  logic               master_en, own_pend, cond_raw, cond_gated;

  irq_agg_edge_det #(.W(NUM_SRC)) edge_i (
    .clk(clk), .rst_n(rst_n), .lvl_i(evt_i), .rise_o(ev_pulse)
  );

  assign latch_ev = ev_pulse & en_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_slot
    irq_agg_slot slot_i (
      .clk(clk), .rst_n(rst_n),
      .ev_i(latch_ev[i]), .clr_i(clr_vec[i]),
      .vis_o(ident_vis[i]), .queued_o(ident_q[i])
    );
  end

  assign own_pend = |(ident_vis & ~mask_q);
  assign cond_raw = own_pend | (|sub_pend_i);

  irq_agg_regs #(.NUM_SRC(NUM_SRC), .NUM_SUB(NUM_SUB), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .ident_i(ident_vis), .sub_i(sub_pend_i), .own_pend_i(own_pend),
    .rdata_o(reg_rdata_o), .mask_o(mask_q), .en_o(en_q),
    .master_o(master_en), .clr_o(clr_vec)
  );

  irq_agg_line line_i (
    .clk(clk), .rst_n(rst_n), .master_i(master_en), .cond_i(cond_raw),
    .gated_o(cond_gated), .irq_o(cpu_irq_o)
  );
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
  parameter int NUM_SRC = 32,
  parameter int NUM_SUB = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] en_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic               master_en,
  input logic [NUM_SRC-1:0] ident_vis,
  input logic [NUM_SRC-1:0] ident_q,
  input logic [NUM_SRC-1:0] clr_vec,
  input logic [NUM_SRC-1:0] latch_ev,
  input logic [NUM_SUB-1:0] sub_pend,
  input logic               cpu_irq
);
  // R2
  ident_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ident_vis & ~$past(ident_vis) & ~$past(en_q)) == '0);

  // R3
  irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_irq) |-> $past(master_en && ((|(ident_vis & ~mask_q)) || (|sub_pend))));

  // R4
  queue_survives_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_vec & ident_q)) |=> (($past(clr_vec & ident_q) & ~ident_vis) == '0));

  // R5
  clear_with_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_vec & latch_ev)) |=> (($past(clr_vec & latch_ev) & ~ident_vis) == '0));

  // R6
  irq_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irq && master_en) |=> cpu_irq);

  // R7
  master_off_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |=> !cpu_irq);
endmodule

bind irq_agg irq_agg_chk #(.NUM_SRC(NUM_SRC), .NUM_SUB(NUM_SUB)) chk_i (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .mask_q(mask_q),
  .master_en(master_en), .ident_vis(ident_vis), .ident_q(ident_q),
  .clr_vec(clr_vec), .latch_ev(latch_ev), .sub_pend(sub_pend_i),
  .cpu_irq(cpu_irq_o)
);

// File: tb/irq_agg_tb_top.sv
`timescale 1ns/1ps
module irq_agg_tb_top;
  localparam int NS = 32;
  localparam int NB = 4;
  localparam int DW = 32;
  localparam logic [1:0] AM = 2'd0, AE = 2'd1, AI = 2'd2, AC = 2'd3;
  localparam logic [31:0] MON = 32'h8000_0000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] evt = '0;
  logic [NB-1:0] sub = '0;
  logic          we = 1'b0;
  logic [1:0]    addr = 2'd0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  irq_agg #(.NUM_SRC(NS), .NUM_SUB(NB), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .sub_pend_i(sub),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .cpu_irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic pulse(input int b);
    @(negedge clk);
    evt[b] = 1'b1;
    @(negedge clk);
    evt[b] = 1'b0;
  endtask

  task automatic clr_and_event(input int b);
    @(negedge clk);
    evt[b] = 1'b1; we = 1'b1; addr = AI; wdata = 32'h1 << b;
    @(negedge clk);
    evt[b] = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(AM, d); check("R1 mask", d, 32'hFFFF_FFFF);
    rd(AE, d); check("R1 enable", d, 0);
    rd(AI, d); check("R1 identity", d, 0);
    rd(AC, d); check("R1 master", d, 0);
    check("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_enable_gate();
    logic [31:0] d;
    pulse(3);
    rd(AI, d); check("R2 disabled source", d, 0);
    wr(AE, 32'h28);
    pulse(3);
    rd(AI, d); check("R2 enabled source", d, 32'h8);
    wr(AI, 32'h8);
    rd(AI, d); check("R2 cleared", d, 0);
    @(negedge clk); evt[5] = 1'b1;
    step(3);
    rd(AI, d); check("R2 held level latches", d, 32'h20);
    wr(AI, 32'h20);
    step(2);
    rd(AI, d); check("R2 held level single event", d, 0);
    @(negedge clk); evt[5] = 1'b0;
    wr(AE, 0);
  endtask

  task automatic t_queue();
    logic [31:0] d;
    wr(AE, 32'h80);
    pulse(7); pulse(7); pulse(7);
    rd(AI, d); check("R4 set", d, 32'h80);
    wr(AI, 32'h80);
    rd(AI, d); check("R4 queued event revealed", d, 32'h80);
    wr(AI, 32'h80);
    rd(AI, d); check("R4 drained, overflow dropped", d, 0);
    wr(AE, 0);
  endtask

  task automatic t_same_cycle();
    logic [31:0] d;
    wr(AE, 32'h200);
    pulse(9);
    clr_and_event(9);
    rd(AI, d); check("R5 one held, clear plus event", d, 32'h200);
    wr(AI, 32'h200);
    rd(AI, d); check("R5 only one remained", d, 0);
    clr_and_event(9);
    rd(AI, d); check("R5 empty, clear plus event", d, 32'h200);
    wr(AI, 32'h200);
    rd(AI, d); check("R5 empty case drained", d, 0);
    wr(AE, 0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(AE, 32'h10);
    wr(AC, MON);
    pulse(4);
    step(3);
    check("R3 masked no irq", {31'b0, irq}, 0);
    rd(AI, d); check("R3 masked still latched", d, 32'h10);
    rd(AC, d); check("R8 own pending masked", d, MON);
    wr(AM, ~32'h10);
    check("R3 unmask latency", {31'b0, irq}, 0);
    step(1);
    check("R3 unmask raises irq", {31'b0, irq}, 1);
    rd(AC, d); check("R8 own pending bit", d, 32'hC000_0000);
    wr(AI, 32'h10);
    wr(AC, 0);
    step(1);
    wr(AM, 32'hFFFF_FFFF);
    wr(AE, 0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr(AM, ~32'h6);
    wr(AE, 32'h6);
    wr(AC, MON);
    step(1);
    check("R6 idle no irq", {31'b0, irq}, 0);
    pulse(1);
    check("R6 one-cycle latency", {31'b0, irq}, 0);
    step(1);
    check("R6 rise", {31'b0, irq}, 1);
    wr(AI, 32'h2);
    step(2);
    check("R6 holds after clear", {31'b0, irq}, 1);
    wr(AC, 0);
    pulse(2);
    check("R7 drop on master off", {31'b0, irq}, 0);
    step(3);
    check("R7 pending while off no irq", {31'b0, irq}, 0);
    rd(AI, d); check("R7 event kept while off", d, 32'h4);
    wr(AC, MON);
    check("R9 re-enable latency", {31'b0, irq}, 0);
    step(1);
    check("R9 fresh edge on re-enable", {31'b0, irq}, 1);
    wr(AI, 32'h6);
    wr(AC, 0);
    step(1);
    wr(AE, 0);
    wr(AM, 32'hFFFF_FFFF);
  endtask

  task automatic t_sub();
    logic [31:0] d;
    @(negedge clk); sub = 4'b0101;
    step(3);
    check("R8 sub ignored while master off", {31'b0, irq}, 0);
    rd(AC, d); check("R8 sub level readback", d, 32'h5);
    wr(AC, MON);
    step(1);
    check("R8 sub raises irq", {31'b0, irq}, 1);
    @(negedge clk); sub = '0;
    rd(AC, d); check("R8 sub acked readback", d, MON);
    wr(AC, 0);
    step(1);
    check("R7 sub path dropped", {31'b0, irq}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_enable_gate();
    t_queue();
    t_same_cycle();
    t_mask();
    t_edge();
    t_sub();
    step(2);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule